// File: doc/BRIEF.md
# Flash Self-Programming Command Sequencer

This block lets a CPU start page operations on an on-chip flash array through a small control register. Software writes a command code to the register, then issues a store strobe. The block accepts the strobe only if it comes within a short window after the register write. It then issues one of three operations to the flash macro: loading one data word into the page buffer, erasing a page, or writing the buffered page.

For erase and page write, the block holds a busy flag and blocks reads of the read-while-write region of the array. If the target page lies in the other region, which cannot be read during programming, the block also stalls the CPU until the macro reports done. The busy flag stays set after the operation completes. Software clears it with a separate re-enable command. An interrupt line is asserted continuously while it is enabled and no command is pending or running.

Top module: `flash_selfprog_seq`

## Requirements
- R1: The control register has these fields: bit 0 is the command-pending flag, bit 1 selects erase, bit 2 selects write, bit 6 is the busy flag and bit 7 is the interrupt enable. The interrupt enable is stored from every accepted write. Low seven bits 0000001 arm a word load, 0000011 arm a page erase and 0000101 arm a page write. 0010001 is the re-enable command. Any other code arms nothing and leaves bits 2:0 read as zero.
- R2: A store strobe sampled at the 1st to 4th rising edge after the register-write edge starts the armed command. If no strobe arrives by the 4th edge, the command is dropped and the pending flag reads 0 after that edge. Only one start pulse is ever active at a time.
- R3: An accepted word load produces a one-cycle `fl_load_go` pulse after the accept edge. The pulse carries the pointer's page field, its word-offset field (the low WORD_BITS bits) and `st_data`. The pending flag clears at the accept edge.
- R4: An accepted erase pulses `fl_erase_go` for one cycle with the page field of the pointer. The word offset and `st_data` are ignored, so `fl_data` keeps its previous value.
- R5: A page write is started (`fl_write_go`) only if the pointer's word-offset field is zero. Otherwise the command is dropped without starting and without setting busy.
- R6: The busy flag and `rww_read_block` go high at the accept edge of an erase or write.
- R7: `cpu_stall` is high from the accept edge until done, and only when the page number is RWW_PAGES or above.
- R8: `fl_done` while an erase or write is running ends it: the stall drops and the pending flag clears, while busy and the read block stay set.
- R9: Writing the re-enable code while no operation is running clears busy and `rww_read_block`.
- R10: `irq` equals the interrupt enable while the pending flag is clear, and is 0 while it is set.
- R11: Register writes are ignored entirely while an erase or write is running, and strobes then start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control/status register read value |
| st_strobe | input | 1 | Store-program-memory strobe |
| st_ptr | input | PAGE_BITS+WORD_BITS | Address pointer: page field above word offset |
| st_data | input | DATA_W | Data word for buffer load |
| fl_page | output | PAGE_BITS | Page number to flash macro |
| fl_word | output | WORD_BITS | Word offset to flash macro |
| fl_data | output | DATA_W | Data word to flash macro |
| fl_load_go | output | 1 | Buffer word load start pulse |
| fl_erase_go | output | 1 | Page erase start pulse |
| fl_write_go | output | 1 | Page write start pulse |
| fl_done | input | 1 | Flash macro operation done |
| rww_read_block | output | 1 | Read-while-write region blocked |
| cpu_stall | output | 1 | CPU halt request |
| irq | output | 1 | Interrupt request |

## Verification
All results are registered. Status bits follow a register write at the next edge. A start pulse, the page/word/data outputs, busy and the stall all appear at the same edge that samples an accepted strobe. The end of an operation shows at the edge that samples `fl_done`. The bench drives inputs on falling edges and samples exactly one falling edge after the edge where a result is due. It sweeps strobe delays from 1 to 6 edges over every page, every command and several offsets, so both sides of the window, both sections and the rejected-write case all fall on a known cycle.

// File: rtl/flash_selfprog_seq.sv
module flash_selfprog_seq #(
  parameter int PAGE_BITS  = 8,
  parameter int WORD_BITS  = 7,
  parameter int DATA_W     = 16,
  parameter int RWW_PAGES  = 224,
  parameter int ARM_CYCLES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ctl_we,
  input  logic [7:0]                     ctl_wdata,
  output logic [7:0]                     ctl_rdata,
  input  logic                           st_strobe,
  input  logic [PAGE_BITS+WORD_BITS-1:0] st_ptr,
  input  logic [DATA_W-1:0]              st_data,
  output logic [PAGE_BITS-1:0]           fl_page,
  output logic [WORD_BITS-1:0]           fl_word,
  output logic [DATA_W-1:0]              fl_data,
  output logic                           fl_load_go,
  output logic                           fl_erase_go,
  output logic                           fl_write_go,
  input  logic                           fl_done,
  output logic                           rww_read_block,
  output logic                           cpu_stall,
  output logic                           irq
);
  localparam int ZW = PAGE_BITS + WORD_BITS;
  localparam int CW = $clog2(ARM_CYCLES + 1);
  localparam logic [PAGE_BITS:0] RWW_LIM = (PAGE_BITS+1)'(RWW_PAGES);

  logic          ie, busy, active, pend, op_er, op_wr, to_nrww;
  logic [CW-1:0] cnt;

  wire [6:0]           code   = ctl_wdata[6:0];
  wire                 wr_ok  = ctl_we && !active;
  wire                 is_ld  = code == 7'h01;
  wire                 is_er  = code == 7'h03;
  wire                 is_wr  = code == 7'h05;
  wire                 is_re  = code == 7'h11;
  wire                 armed  = cnt != '0;
  wire [WORD_BITS-1:0] off    = st_ptr[WORD_BITS-1:0];
  wire [PAGE_BITS-1:0] pg     = st_ptr[ZW-1:WORD_BITS];
  wire                 off_ok = off == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; busy <= 1'b0; active <= 1'b0; pend <= 1'b0;
      op_er <= 1'b0; op_wr <= 1'b0; to_nrww <= 1'b0; cnt <= '0;
      fl_page <= '0; fl_word <= '0; fl_data <= '0;
      fl_load_go <= 1'b0; fl_erase_go <= 1'b0; fl_write_go <= 1'b0;
    end else begin
      fl_load_go  <= 1'b0;
      fl_erase_go <= 1'b0;
      fl_write_go <= 1'b0;
      if (wr_ok) begin
        ie <= ctl_wdata[7];
        if (is_re) busy <= 1'b0;
        pend  <= is_ld || is_er || is_wr;
        op_er <= is_er;
        op_wr <= is_wr;
        cnt   <= (is_ld || is_er || is_wr) ? CW'(ARM_CYCLES) : '0;
      end else if (armed) begin
        if (st_strobe) begin
          cnt <= '0;
          if (!op_er && !op_wr) begin
            fl_load_go <= 1'b1;
            fl_page    <= pg;
            fl_word    <= off;
            fl_data    <= st_data;
            pend       <= 1'b0;
          end else if (op_er || off_ok) begin
            fl_erase_go <= op_er;
            fl_write_go <= op_wr;
            fl_page     <= pg;
            active      <= 1'b1;
            busy        <= 1'b1;
            to_nrww     <= {1'b0, pg} >= RWW_LIM;
          end else begin
            pend <= 1'b0; op_er <= 1'b0; op_wr <= 1'b0;
          end
        end else begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            pend <= 1'b0; op_er <= 1'b0; op_wr <= 1'b0;
          end
        end
      end else if (active && fl_done) begin
        active <= 1'b0;
        pend   <= 1'b0;
        op_er  <= 1'b0;
        op_wr  <= 1'b0;
      end
    end
  end

  assign ctl_rdata      = {ie, busy, 3'b000, op_wr, op_er, pend};
  assign rww_read_block = busy;
  assign cpu_stall      = active && to_nrww;
  assign irq            = ie && !pend;
endmodule

// File: rtl/flash_selfprog_seq_chk.sv
module flash_selfprog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_rdata,
  input logic       fl_load_go,
  input logic       fl_erase_go,
  input logic       fl_write_go,
  input logic       fl_done,
  input logic       rww_read_block,
  input logic       cpu_stall,
  input logic       irq
);
  p_one_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_load_go, fl_erase_go, fl_write_go}));
  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_load_go |=> !fl_load_go);
  p_start_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_erase_go || fl_write_go) |-> rww_read_block);
  p_stall_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> rww_read_block);
  p_busy_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rww_read_block && !ctl_we) |=> rww_read_block);
  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ctl_rdata[0]);
  p_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && ctl_we && !fl_done) |=> ctl_rdata[0]);
endmodule

bind flash_selfprog_seq flash_selfprog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
  .fl_load_go(fl_load_go), .fl_erase_go(fl_erase_go), .fl_write_go(fl_write_go),
  .fl_done(fl_done), .rww_read_block(rww_read_block), .cpu_stall(cpu_stall),
  .irq(irq)
);

// File: tb/flash_selfprog_seq_bench.sv
module flash_selfprog_seq_bench;
  localparam int PB = 3, WB = 2, DW = 16, RWWP = 6;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          ctl_we = 1'b0, st_strobe = 1'b0, fl_done = 1'b0;
  logic [7:0]    ctl_wdata = '0, ctl_rdata;
  logic [PB+WB-1:0] st_ptr = '0;
  logic [DW-1:0] st_data = '0, fl_data;
  logic [PB-1:0] fl_page;
  logic [WB-1:0] fl_word;
  logic          fl_load_go, fl_erase_go, fl_write_go, rww_read_block, cpu_stall, irq;

  int vectors = 0, fails = 0;
  logic [DW-1:0] last_data = '0;

  always #2.5 clk = ~clk;

  flash_selfprog_seq #(.PAGE_BITS(PB), .WORD_BITS(WB), .DATA_W(DW),
                       .RWW_PAGES(RWWP), .ARM_CYCLES(4)) u_flash_selfprog_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .st_strobe(st_strobe), .st_ptr(st_ptr),
    .st_data(st_data), .fl_page(fl_page), .fl_word(fl_word), .fl_data(fl_data),
    .fl_load_go(fl_load_go), .fl_erase_go(fl_erase_go), .fl_write_go(fl_write_go),
    .fl_done(fl_done), .rww_read_block(rww_read_block), .cpu_stall(cpu_stall),
    .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic strobe_at(input int k);
    repeat (k - 1) @(negedge clk);
    st_strobe = 1'b1;
    @(negedge clk); st_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", ctl_rdata, 0);
    chk("R10 reset irq", irq, 0);
    chk("R6 reset block", rww_read_block, 0);
    chk("R7 reset stall", cpu_stall, 0);

    ctl_write(8'h87);
    chk("R1 unknown code arms nothing", ctl_rdata, 8'h80);
    chk("R10 irq with nothing pending", irq, 1);
    strobe_at(1);
    chk("R1 unknown code starts nothing", {fl_load_go, fl_erase_go, fl_write_go}, 0);

    for (int op = 0; op < 3; op++)
      for (int k = 1; k <= 6; k++)
        for (int pg = 0; pg < 8; pg++) begin
          logic [7:0] code;
          logic [WB-1:0] off;
          logic ie, acc, start;
          ie   = pg[0];
          off  = (op == 2) ? ((pg == 3 || pg == 6) ? WB'(pg % 4 + 1) : '0) : WB'((pg + k) % 4);
          code = {ie, 7'(op == 0 ? 1 : (op == 1 ? 3 : 5))};
          acc  = k <= 4;
          start = acc && (op == 1 || (op == 2 && off == 0));
          st_ptr  = {PB'(pg), off};
          st_data = DW'(16'hA000 + pg * 64 + k * 8 + op);

          ctl_write(code);
          chk("R1 armed status", ctl_rdata, code);
          chk("R10 irq low while pending", irq, 0);
          strobe_at(k);
          chk("R2 load pulse", fl_load_go, acc && op == 0);
          chk("R2 erase pulse", fl_erase_go, acc && op == 1);
          chk("R5 write pulse", fl_write_go, start && op == 2);

          if (acc && op == 0) begin
            chk("R3 load page", fl_page, pg);
            chk("R3 load word", fl_word, off);
            chk("R3 load data", fl_data, st_data);
            chk("R3 pending cleared", ctl_rdata[0], 0);
            last_data = st_data;
          end
          if (!start && !(acc && op == 0)) begin
            chk("R2 dropped pending", ctl_rdata[0], 0);
            chk("R5 dropped busy", rww_read_block, 0);
          end
          if (!start) chk("R10 irq idle", irq, ie);

          if (start) begin
            chk("R6 block set", rww_read_block, 1);
            chk("R6 busy bit", ctl_rdata[6], 1);
            chk("R7 stall by section", cpu_stall, pg >= RWWP);
            chk("R4 op page", fl_page, pg);
            chk("R4 data ignored", fl_data, last_data);
            repeat (3) @(negedge clk);
            chk("R7 stall held", cpu_stall, pg >= RWWP);
            chk("R2 single pulse", {fl_erase_go, fl_write_go}, 0);
            ctl_write(8'h01);
            chk("R11 write ignored", ctl_rdata, {ie, 1'b1, 3'b000, op == 2, op == 1, 1'b1});
            strobe_at(1);
            chk("R11 strobe ignored", fl_load_go, 0);
            @(negedge clk); fl_done = 1'b1;
            @(negedge clk); fl_done = 1'b0;
            chk("R8 stall released", cpu_stall, 0);
            chk("R8 pending cleared", ctl_rdata[0], 0);
            chk("R8 busy kept", rww_read_block, 1);
            chk("R10 irq after done", irq, ie);
            ctl_write({ie, 7'h11});
            chk("R9 block cleared", rww_read_block, 0);
            chk("R9 busy bit cleared", ctl_rdata[6], 0);
          end
        end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule